// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one byte into one asynchronous serial frame on a single output line. A frame is built from a low start bit and the eight data bits, least significant bit first. An optional ninth bit may follow the data: either a parity bit or a flag that marks an address frame or a data frame. The frame ends with one or two high stop bits. A single-cycle load strobe starts a frame. At that strobe the block captures the byte, the frame options, a 2-bit base-clock select and a bit-rate divisor. Changes on those inputs while the frame is being sent have no effect on it.

Bit timing comes from two stages. The first is a prescaler that divides the system clock by 1, 4, 16 or 64. The second is a bit-rate counter that counts `divisor+1` prescaled periods for each bit. A busy flag covers the whole frame, and a one-cycle done pulse marks its end. A load strobe that arrives while a frame is in progress is ignored.

Top module: `async_frame_tx`

## Requirements
- R1: Out of reset, and at any time no frame is in progress, `txd` is 1, `busy` is 0 and `done` is 0. Asserting `rst_n` low during a frame returns the block to this state.
- R2: A frame starts with a start bit of 0. Then `data_in[0]` through `data_in[7]` are sent in that order.
- R3: With `par_en`=1 and `mp_en`=0, one parity bit follows the data. For `par_odd`=0 the bit equals the XOR of the eight data bits (even parity). For `par_odd`=1 it is the inverse of that XOR (odd parity).
- R4: With `par_en`=0 and `mp_en`=0, the stop bits follow the data bits directly, so the frame has no ninth bit.
- R5: The frame ends with one stop bit of 1 when `stop_two`=0, and with two stop bits of 1 when `stop_two`=1.
- R6: With `mp_en`=1, the bit after the data equals `mp_flag` (1 marks an address frame, 0 a data frame). No parity bit is sent, whatever the values of `par_en` and `par_odd`.
- R7: Every bit lasts (`divisor`+1)·K clock cycles. K is 1, 4, 16 or 64 for `clk_sel` = 00, 01, 10 or 11. The start bit begins on the clock edge that samples the load.
- R8: `busy` rises on the edge that samples an accepted load. It stays high until the last stop bit ends. On that same edge `done` goes high for exactly one cycle.
- R9: The data, the frame options, `clk_sel` and `divisor` are captured on the accepted load. Changing them later in the frame leaves that frame unchanged.
- R10: A load strobe while `busy` is 1 is ignored: the frame in progress keeps its bits and its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Start-of-frame strobe, one cycle |
| data_in | input | 8 | Byte to send |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| stop_two | input | 1 | 0 gives one stop bit, 1 gives two |
| mp_en | input | 1 | Send the address/data flag in place of parity |
| mp_flag | input | 1 | Flag value: 1 for an address frame, 0 for a data frame |
| clk_sel | input | 2 | Prescale select: 00 is /1, 01 is /4, 10 is /16, 11 is /64 |
| divisor | input | DIV_W | Bit-rate divisor; each bit lasts divisor+1 prescaled periods |
| txd | output | 1 | Serial output line, high when idle |
| busy | output | 1 | High while a frame is being sent |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench uses the default `DIV_W` of 8 and keeps divisors between 0 and 3. Bit periods then run from 1 cycle (`clk_sel`=00, divisor 0) up to 64 cycles (`clk_sel`=11). Each of the four prescale ratios, and the degenerate case of a one-cycle bit, is reached in a few hundred cycles. Frame lengths of 10, 11 and 12 bits are all covered. The directed tests change the frame inputs after a load, pulse load mid-frame and reset mid-frame.

// File: rtl/afx_pkg.sv
`timescale 1ns/1ps
package afx_pkg;

  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 4;   // start + data + extra + two stops
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int PRE_W   = 6;            // holds ratio-1 for /64

  // Prescale ratio minus one for the 2-bit select: 0, 3, 15, 63.
  function automatic logic [PRE_W-1:0] prescale_last(input logic [1:0] sel);
    logic [PRE_W:0] ratio;
    ratio = (PRE_W+1)'(1) << (2 * sel);
    return PRE_W'(ratio - 1'b1);
  endfunction

  // Parity bit over the data: even makes the one count even.
  function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // Number of bits on the line for one frame.
  function automatic logic [LEN_W-1:0] frame_bits(input logic extra, input logic two_stop);
    return LEN_W'(DATA_W + 2) + LEN_W'(extra) + LEN_W'(two_stop);
  endfunction

  // Frame image, bit 0 goes out first; unused upper bits are idle-high.
  function automatic logic [FRAME_W-1:0] frame_image(
      input logic [DATA_W-1:0] d,
      input logic pe, input logic odd,
      input logic mp, input logic flag);
    logic [FRAME_W-1:0] img;
    img = '1;
    img[0] = 1'b0;
    img[DATA_W:1] = d;
    if (mp)      img[DATA_W+1] = flag;
    else if (pe) img[DATA_W+1] = parity_of(d, odd);
    return img;
  endfunction

endpackage

// File: rtl/afx_prescaler.sv
`timescale 1ns/1ps
module afx_prescaler
  import afx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last_w;

  assign last_w = prescale_last(sel);
  assign tick   = (cnt_q == last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/afx_bit_timer.sv
`timescale 1ns/1ps
module afx_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [DIV_W-1:0] limit,
  output logic             bit_end
);

  logic [DIV_W-1:0] cnt_q;

  assign bit_end = tick && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (bit_end) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/afx_frame_shifter.sv
`timescale 1ns/1ps
module afx_frame_shifter
  import afx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] image,
  input  logic [LEN_W-1:0]   nbits,
  input  logic               bit_end,
  output logic               line,
  output logic               busy,
  output logic               done,
  output logic               last_end
);

  logic [FRAME_W-1:0] sr_q;
  logic [LEN_W-1:0]   left_q;
  logic               busy_q;
  logic               done_q;

  assign last_end = busy_q && bit_end && (left_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        sr_q   <= image;
        left_q <= nbits;
        busy_q <= 1'b1;
      end else if (busy_q && bit_end) begin
        sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
        if (last_end) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign line = busy_q ? sr_q[0] : 1'b1;
  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/async_frame_tx.sv
`timescale 1ns/1ps
module async_frame_tx
  import afx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop_two,
  input  logic              mp_en,
  input  logic              mp_flag,
  input  logic [1:0]        clk_sel,
  input  logic [DIV_W-1:0]  divisor,
  output logic              txd,
  output logic              busy,
  output logic              done
);

  // Named internal events, visible to the bound checker.
  logic               accept_w;
  logic               tick_w;
  logic               bit_end_w;
  logic               last_end_w;
  logic [FRAME_W-1:0] image_w;
  logic [LEN_W-1:0]   nbits_w;

  logic [1:0]         sel_q;
  logic [DIV_W-1:0]   div_q;

  assign accept_w = load && !busy;
  assign image_w  = frame_image(data_in, par_en, par_odd, mp_en, mp_flag);
  assign nbits_w  = frame_bits(mp_en || par_en, stop_two);

  // Timing settings are held for the whole frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      div_q <= '0;
    end else if (accept_w) begin
      sel_q <= clk_sel;
      div_q <= divisor;
    end
  end

  afx_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept_w),
    .sel     (sel_q),
    .tick    (tick_w)
  );

  afx_bit_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept_w),
    .tick    (tick_w),
    .limit   (div_q),
    .bit_end (bit_end_w)
  );

  afx_frame_shifter u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept_w),
    .image    (image_w),
    .nbits    (nbits_w),
    .bit_end  (bit_end_w),
    .line     (txd),
    .busy     (busy),
    .done     (done),
    .last_end (last_end_w)
  );

endmodule

// File: rtl/afx_checker.sv
`timescale 1ns/1ps
module afx_checker (
  input logic clk,
  input logic rst_n,
  input logic load,
  input logic txd,
  input logic busy,
  input logic done,
  input logic bit_end_w,
  input logic last_end_w
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  p_stop_before_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txd));

  p_bit_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end_w) |=> (busy && $stable(txd)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  p_last_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_end_w |=> (done && !busy));

  p_load_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load && !bit_end_w) |=> (busy && $stable(txd)));

endmodule

bind async_frame_tx afx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load       (load),
  .txd        (txd),
  .busy       (busy),
  .done       (done),
  .bit_end_w  (bit_end_w),
  .last_end_w (last_end_w)
);

// File: tb/test_async_frame_tx.sv
`timescale 1ns/1ps
module test_async_frame_tx;

  typedef struct packed {
    logic [7:0] d;
    logic       pe;
    logic       odd;
    logic       s2;
    logic       mp;
    logic       fl;
    logic [1:0] sel;
    logic [7:0] dv;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd3},  // R4 plain, one stop
    '{8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd1},  // R3 even
    '{8'h3D, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 8'd0},  // R3 even, R5 two stops, /4
    '{8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd2},  // R3 odd
    '{8'h7F, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 8'd0},  // R3 odd, /16
    '{8'h55, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 8'd0},  // R7 /64
    '{8'h12, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 8'd1},  // R6 address
    '{8'hFE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 8'd1},  // R6 data
    '{8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0},  // R7 one-cycle bits
    '{8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 8'd1}   // R3 even, /16 x2
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [7:0] data_in = '0;
  logic       par_en = 1'b0, par_odd = 1'b0, stop_two = 1'b0;
  logic       mp_en = 1'b0, mp_flag = 1'b0;
  logic [1:0] clk_sel = '0;
  logic [7:0] divisor = '0;
  logic       txd, busy, done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  async_frame_tx i_async_frame_tx (
    .clk(clk), .rst_n(rst_n), .load(load), .data_in(data_in),
    .par_en(par_en), .par_odd(par_odd), .stop_two(stop_two),
    .mp_en(mp_en), .mp_flag(mp_flag), .clk_sel(clk_sel),
    .divisor(divisor), .txd(txd), .busy(busy), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Expected line bit j of a frame, built from the requirements.
  function automatic logic exp_bit(input vec_t v, input int j);
    int extra;
    extra = (v.mp || v.pe) ? 1 : 0;
    if (j == 0) return 1'b0;
    if (j <= 8) return v.d[j-1];
    if (j == 9 && extra == 1) begin
      if (v.mp) return v.fl;
      return ($countones(v.d) % 2 == 1) ^ v.odd;
    end
    return 1'b1;
  endfunction

  function automatic int exp_len(input vec_t v);
    return 10 + ((v.mp || v.pe) ? 1 : 0) + (v.s2 ? 1 : 0);
  endfunction

  function automatic int exp_period(input vec_t v);
    return (int'(v.dv) + 1) * (1 << (2 * int'(v.sel)));
  endfunction

  task automatic apply(input vec_t v);
    data_in = v.d; par_en = v.pe; par_odd = v.odd; stop_two = v.s2;
    mp_en = v.mp; mp_flag = v.fl; clk_sel = v.sel; divisor = v.dv;
  endtask

  // Sends one frame and checks it. scramble: change every input right after
  // the load (R9). poke: pulse load with other data mid-frame (R10).
  task automatic run_frame(input vec_t v, input bit scramble, input bit poke);
    int t, len;
    t = exp_period(v);
    len = exp_len(v);
    @(negedge clk);
    apply(v);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check("R8 busy after load", busy, 1);
    if (scramble) begin
      data_in = ~v.d; par_en = ~v.pe; par_odd = ~v.odd; stop_two = ~v.s2;
      mp_en = ~v.mp; mp_flag = ~v.fl; clk_sel = ~v.sel; divisor = v.dv + 8'd2;
    end
    for (int c = 0; c < len * t; c++) begin
      if (poke && c == 2) begin
        load = 1'b1; data_in = ~v.d; stop_two = ~v.s2;
      end
      if (poke && c == 3) load = 1'b0;
      if (c % t == t / 2)
        check($sformatf("R2/R3/R4/R5/R6/R7 bit %0d of %02h", c / t, v.d),
              txd, exp_bit(v, c / t));
      if (c == len * t - 1) check("R8 busy to last stop", busy, 1);
      if (c == len * t - 1) check("R8 no early done", done, 0);
      @(negedge clk);
    end
    load = 1'b0;
    check("R8 done pulse", done, 1);
    check("R8 busy cleared", busy, 0);
    check("R1 line idle after frame", txd, 1);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    vec_t dv;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset txd", txd, 1);
    check("R1 reset busy", busy, 0);
    check("R1 reset done", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle txd", txd, 1);

    for (int i = 0; i < NV; i++) begin
      run_frame(VECS[i], 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      check("R1 idle between frames", txd, 1);
    end

    // R9: inputs changed during the frame
    run_frame(VECS[2], 1'b1, 1'b0);
    run_frame(VECS[6], 1'b1, 1'b0);
    // R10: load while busy
    run_frame(VECS[3], 1'b0, 1'b1);
    run_frame(VECS[7], 1'b0, 1'b1);
    // R6: parity settings ignored under flag mode
    dv = '{8'hC3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 8'd0};
    run_frame(dv, 1'b0, 1'b0);

    // R1: reset during a frame
    @(negedge clk);
    apply(VECS[5]);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-frame busy", busy, 0);
    check("R1 reset mid-frame txd", txd, 1);
    check("R1 reset mid-frame done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(VECS[0], 1'b0, 1'b0);

    summary();
  end

endmodule